// File: doc/BRIEF.md
# Predicated Vector Compare-and-Branch Unit

This unit runs one vector compare-and-branch operation over up to 64 element pairs. A start pulse captures the vector length, a 64-bit predicate with its invert and zeroing flags, the fail-on-first flag, the relation code, the sub-group size and the result-destination settings. The unit then steps through the elements one per clock from index 0 upward. It puts the current index on `elemIdx`, and the surrounding pipeline returns that element's two operands in the same cycle. Each active element is compared, and its outcome is written into a result bitmask.

When the element pass ends, a separate decision cycle applies one of four consensus rules to the finished mask. The rule is chosen by the invert and zeroing bits of the result destination: every active element passed, at least one failed, at least one passed, or none passed. With fail-on-first set, the pass stops at the first failing element and the reported vector length is cut back. When sub-groups are in use, it is cut back to the start of the sub-group that contains the failure. The mask, the new length, the branch flag and a one-cycle `done` pulse are presented together. They hold their values until the next accepted start.

Top module: `vec_cmp_branch`

## Requirements
- R1: After reset, `done`, `branchTaken`, `resultMask` and `vlOut` are all zero. A start is accepted only when the unit is idle. Starts that arrive while it is busy are ignored. Elements are visited one per clock with `elemIdx` rising by one each cycle. `done` is high for exactly one cycle. The outputs then hold until the next accepted start.
- R2: `relSel` selects the element relation applied to operand A against operand B. The codes are 0 = EQ, 1 = NE, 4 = signed LT, 5 = signed GE, 6 = unsigned LT and 7 = unsigned GE. Codes 2 and 3 make every compare fail.
- R3: The mask starts at ones in bits below VL and zeros above in two cases: `dstPresent` is 0, or `srcZeroing` is 1. Otherwise the mask starts from `priorMask`.
- R4: With `srcInvert` = 1 the predicate is complemented before use. An element whose effective predicate bit is 0 is inactive. In non-zeroing mode an inactive element keeps its initial mask bit, and it never counts as a failure, even under fail-on-first.
- R5: In zeroing mode, each inactive element below VL gets mask bit 0 and counts as a failure.
- R6: Without fail-on-first, every element below VL is processed and `vlOut` equals VL.
- R7: With fail-on-first and a sub-group size of 1, the pass stops at the first failing element. That element's bit is written as 0, no later bit changes, and `vlOut` equals that element's index.
- R8: With fail-on-first and a sub-group size of 2^`subVlLog2` greater than 1, `vlOut` is the failing index rounded down to a multiple of the sub-group size.
- R9: Rule "all pass" is selected by destination invert = 0 and zeroing = 0, or by `dstPresent` = 0 whatever the flags are. It branches when every active element below the new VL has its mask bit set.
- R10: Rule "any fails" is selected by destination invert = 1 and zeroing = 0. It branches exactly when rule "all pass" would not.
- R11: Rule "any passes" is selected by destination invert = 0 and zeroing = 1. It branches when any mask bit below the new VL is set.
- R12: Rule "none pass" is selected by destination invert = 1 and zeroing = 1. It branches when no mask bit below the new VL is set.
- R13: If VL is 0 or no element is active, no compare is made. The mask equals its initial value, `vlOut` equals VL, and the branch rule is applied to that initial mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| vlIn | input | 7 | Vector length, 0 to 64 |
| predIn | input | 64 | Source predicate mask |
| srcInvert | input | 1 | Complement the source predicate |
| srcZeroing | input | 1 | Inactive elements fail and are cleared |
| failFirst | input | 1 | Stop on the first failing element |
| dstPresent | input | 1 | A result destination exists |
| dstInvert | input | 1 | Destination invert bit (rule select) |
| dstZeroing | input | 1 | Destination zeroing bit (rule select) |
| priorMask | input | 64 | Prior destination contents |
| relSel | input | 3 | Relation code |
| subVlLog2 | input | 2 | log2 of the sub-group size |
| elemIdx | output | 6 | Index of the element being compared |
| aElem | input | ELEM_W | Operand A for `elemIdx` |
| bElem | input | ELEM_W | Operand B for `elemIdx` |
| resultMask | output | 64 | Comparison bitmask |
| vlOut | output | 7 | Vector length after the operation |
| branchTaken | output | 1 | Consensus branch decision |
| done | output | 1 | One-cycle completion pulse |

## Verification
Early termination by a failed compare and normal termination at the end of VL can land on the same element. When the failure falls on index VL-1, both exits compete in one cycle. The bench provokes this with an unsigned compare that first fails on the last element. It judges the result by requiring `vlOut` to equal VL-1, with the mask bits below VL-1 set and the decision made on the shortened range. A second case puts the failure inside a sub-group, so that truncation rounds down while the element pass stops in the same cycle.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_LT  = 3'd4,
    REL_GE  = 3'd5,
    REL_LTU = 3'd6,
    REL_GEU = 3'd7
  } relCode_e;

  // Strobes from the sequencer to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic load;    // capture configuration and initial mask
    logic step;    // process element at current index
    logic finish;  // post-analysis: evaluate consensus rule
  } vcbStrobe_t;

endpackage

// File: rtl/vcb_compare.sv
module vcb_compare #(
  parameter int ELEM_W = 32
) (
  input  logic [ELEM_W-1:0] opA,
  input  logic [ELEM_W-1:0] opB,
  input  logic [2:0]        rel,
  output logic              pass
);
  import vcb_pkg::*;

  logic isEq, isLtS, isLtU;

  always_comb begin
    isEq  = (opA == opB);
    isLtS = ($signed(opA) < $signed(opB));
    isLtU = (opA < opB);
    case (rel)
      REL_EQ:  pass = isEq;
      REL_NE:  pass = !isEq;
      REL_LT:  pass = isLtS;
      REL_GE:  pass = !isLtS;
      REL_LTU: pass = isLtU;
      REL_GEU: pass = !isLtU;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/vcb_ctrl.sv
module vcb_ctrl #(
  parameter int VL_W  = 7,
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [VL_W-1:0]      vlIn,
  input  logic                 emptyStart,
  input  logic                 stopNow,
  output vcb_pkg::vcbStrobe_t  strobe,
  output logic [IDX_W-1:0]     elemIdx,
  output logic                 done
);
  import vcb_pkg::*;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DECIDE} seqState_e;

  seqState_e       state;
  logic [VL_W-1:0] vlHeld;
  logic            lastElem;

  always_comb begin
    strobe.load   = (state == S_IDLE) && start;
    strobe.step   = (state == S_RUN);
    strobe.finish = (state == S_DECIDE);
    lastElem      = ((VL_W'(elemIdx) + VL_W'(1)) == vlHeld);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      elemIdx <= '0;
      vlHeld  <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.finish;
      case (state)
        S_IDLE: begin
          if (start) begin
            vlHeld  <= vlIn;
            elemIdx <= '0;
            state   <= emptyStart ? S_DECIDE : S_RUN;
          end
        end
        S_RUN: begin
          if (stopNow || lastElem) state <= S_DECIDE;
          else                     elemIdx <= elemIdx + IDX_W'(1);
        end
        S_DECIDE: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vcb_dpath.sv
module vcb_dpath #(
  parameter int ELEM_W = 32,
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int IDX_W  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vcb_pkg::vcbStrobe_t  strobe,
  input  logic [IDX_W-1:0]     elemIdx,
  input  logic [VL_W-1:0]      vlIn,
  input  logic [MAX_VL-1:0]    predIn,
  input  logic                 srcInvert,
  input  logic                 srcZeroing,
  input  logic                 failFirst,
  input  logic                 dstPresent,
  input  logic                 dstInvert,
  input  logic                 dstZeroing,
  input  logic [MAX_VL-1:0]    priorMask,
  input  logic [2:0]           relSel,
  input  logic [1:0]           subVlLog2,
  input  logic [ELEM_W-1:0]    aElem,
  input  logic [ELEM_W-1:0]    bElem,
  output logic                 emptyStart,
  output logic                 stopNow,
  output logic [MAX_VL-1:0]    resultMask,
  output logic [VL_W-1:0]      vlOut,
  output logic                 branchTaken
);
  import vcb_pkg::*;

  function automatic logic [MAX_VL-1:0] lowOnes(input logic [VL_W-1:0] n);
    logic [MAX_VL-1:0] m;
    for (int i = 0; i < MAX_VL; i++) m[i] = (VL_W'(i) < n);
    return m;
  endfunction

  // Captured configuration
  logic [MAX_VL-1:0] cfgPred;
  logic              cfgZero, cfgFf, cfgInv, cfgZrule;
  logic [2:0]        cfgRel;
  logic [VL_W-1:0]   cfgGrpMask;

  logic [MAX_VL-1:0] effPredIn, vlRangeIn, keptRange, keptActive;
  logic              cmpPass, elemActive, elemFail, elemBit, ruleAll, ruleAny;

  vcb_compare #(.ELEM_W(ELEM_W)) cmp_i (
    .opA (aElem),
    .opB (bElem),
    .rel (cfgRel),
    .pass(cmpPass)
  );

  always_comb begin
    vlRangeIn  = lowOnes(vlIn);
    effPredIn  = (srcInvert ? ~predIn : predIn) & vlRangeIn;
    emptyStart = (vlIn == '0) || (effPredIn == '0);

    elemActive = cfgPred[elemIdx];
    elemFail   = elemActive ? !cmpPass : cfgZero;
    elemBit    = elemActive ? cmpPass  : (cfgZero ? 1'b0 : resultMask[elemIdx]);
    stopNow    = strobe.step && cfgFf && elemFail;

    keptRange  = lowOnes(vlOut);
    keptActive = cfgPred & keptRange;
    ruleAll    = ((resultMask & keptActive) == keptActive);
    ruleAny    = |(resultMask & keptRange);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgPred     <= '0;
      cfgZero     <= 1'b0;
      cfgFf       <= 1'b0;
      cfgInv      <= 1'b0;
      cfgZrule    <= 1'b0;
      cfgRel      <= '0;
      cfgGrpMask  <= '0;
      resultMask  <= '0;
      vlOut       <= '0;
      branchTaken <= 1'b0;
    end else begin
      if (strobe.load) begin
        cfgPred    <= effPredIn;
        cfgZero    <= srcZeroing;
        cfgFf      <= failFirst;
        cfgInv     <= dstPresent && dstInvert;
        cfgZrule   <= dstPresent && dstZeroing;
        cfgRel     <= relSel;
        cfgGrpMask <= VL_W'((4'd1 << subVlLog2) - 4'd1);
        resultMask <= (!dstPresent || srcZeroing) ? vlRangeIn : priorMask;
        vlOut      <= vlIn;
      end
      if (strobe.step) begin
        resultMask[elemIdx] <= elemBit;
        if (cfgFf && elemFail) vlOut <= VL_W'(elemIdx) & ~cfgGrpMask;
      end
      if (strobe.finish) begin
        case ({cfgInv, cfgZrule})
          2'b00:   branchTaken <= ruleAll;
          2'b10:   branchTaken <= !ruleAll;
          2'b01:   branchTaken <= ruleAny;
          default: branchTaken <= !ruleAny;
        endcase
      end
    end
  end

endmodule

// File: rtl/vec_cmp_branch.sv
module vec_cmp_branch #(
  parameter int ELEM_W = 32,
  parameter int MAX_VL = 64,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VL_W-1:0]   vlIn,
  input  logic [MAX_VL-1:0] predIn,
  input  logic              srcInvert,
  input  logic              srcZeroing,
  input  logic              failFirst,
  input  logic              dstPresent,
  input  logic              dstInvert,
  input  logic              dstZeroing,
  input  logic [MAX_VL-1:0] priorMask,
  input  logic [2:0]        relSel,
  input  logic [1:0]        subVlLog2,
  output logic [IDX_W-1:0]  elemIdx,
  input  logic [ELEM_W-1:0] aElem,
  input  logic [ELEM_W-1:0] bElem,
  output logic [MAX_VL-1:0] resultMask,
  output logic [VL_W-1:0]   vlOut,
  output logic              branchTaken,
  output logic              done
);
  import vcb_pkg::*;

  vcbStrobe_t strobe;
  logic       emptyStart, stopNow;

  vcb_ctrl #(.VL_W(VL_W), .IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .vlIn      (vlIn),
    .emptyStart(emptyStart),
    .stopNow   (stopNow),
    .strobe    (strobe),
    .elemIdx   (elemIdx),
    .done      (done)
  );

  vcb_dpath #(.ELEM_W(ELEM_W), .MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .elemIdx    (elemIdx),
    .vlIn       (vlIn),
    .predIn     (predIn),
    .srcInvert  (srcInvert),
    .srcZeroing (srcZeroing),
    .failFirst  (failFirst),
    .dstPresent (dstPresent),
    .dstInvert  (dstInvert),
    .dstZeroing (dstZeroing),
    .priorMask  (priorMask),
    .relSel     (relSel),
    .subVlLog2  (subVlLog2),
    .aElem      (aElem),
    .bElem      (bElem),
    .emptyStart (emptyStart),
    .stopNow    (stopNow),
    .resultMask (resultMask),
    .vlOut      (vlOut),
    .branchTaken(branchTaken)
  );

endmodule

// File: rtl/vcb_checker.sv
module vcb_checker #(
  parameter int MAX_VL = 64,
  parameter int VL_W   = 7,
  parameter int IDX_W  = 6
) (
  input logic                clk,
  input logic                rstN,
  input logic [VL_W-1:0]     vlIn,
  input logic                failFirst,
  input vcb_pkg::vcbStrobe_t strobe,
  input logic [IDX_W-1:0]    elemIdx,
  input logic [MAX_VL-1:0]   resultMask,
  input logic [VL_W-1:0]     vlOut,
  input logic                branchTaken,
  input logic                done
);
  logic [VL_W-1:0] heldVl;
  logic            heldFf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldVl <= '0;
      heldFf <= 1'b0;
    end else if (strobe.load) begin
      heldVl <= vlIn;
      heldFf <= failFirst;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R1
  AST_DONE_AFTER_DECIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> done);  // R1
  AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && $past(strobe.step)) |-> (elemIdx == IDX_W'($past(elemIdx) + 1'b1)));  // R1
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(resultMask));  // R1
  AST_BRANCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(branchTaken));  // R1
  AST_FULL_VL_NO_FF: assert property (@(posedge clk) disable iff (!rstN)
    (done && !heldFf) |-> (vlOut == heldVl));  // R6
  AST_VL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (vlOut <= heldVl));  // R7

endmodule

bind vec_cmp_branch vcb_checker #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .vlIn       (vlIn),
  .failFirst  (failFirst),
  .strobe     (strobe),
  .elemIdx    (elemIdx),
  .resultMask (resultMask),
  .vlOut      (vlOut),
  .branchTaken(branchTaken),
  .done       (done)
);

// File: tb/vec_cmp_branch_tb_top.sv
module vec_cmp_branch_tb_top;

  localparam int W = 32;

  typedef struct packed {
    logic [6:0]  vl;
    logic [63:0] pred;
    logic        sInv, sZero, ff, hasDst, dInv, dZero;
    logic [2:0]  rel;
    logic [1:0]  sub;
    logic [63:0] prior;
    logic [31:0] aBase, aStep, bConst;
  } vec_t;

  localparam logic [63:0] ALL = '1;
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'd8,  ALL,    0,0,0,1,0,0, 3'd0, 2'd0, 64'h0,  32'd5, 32'd0, 32'd5},     // R2 EQ, R9
    '{7'd8,  ALL,    0,0,0,1,1,0, 3'd1, 2'd0, 64'h0,  32'd0, 32'd1, 32'd3},     // R2 NE, R10
    '{7'd8,  ALL,    0,0,0,1,0,1, 3'd4, 2'd0, 64'h0,  32'hFFFFFFFC, 32'd1, 32'd0}, // R2 LT, R11
    '{7'd8,  ALL,    0,0,0,1,1,1, 3'd5, 2'd0, 64'h0,  32'd0, 32'd1, 32'd100},   // R2 GE, R12
    '{7'd8,  ALL,    0,0,1,1,0,0, 3'd6, 2'd0, 64'h0,  32'hFFFFFFFC, 32'd1, 32'd0}, // R7 fail at 0
    '{7'd10, ALL,    0,0,1,1,0,0, 3'd6, 2'd0, 64'h0,  32'd0, 32'd1, 32'd5},     // R7 fail at 5
    '{7'd10, ALL,    0,0,1,1,0,0, 3'd6, 2'd2, 64'h0,  32'd0, 32'd1, 32'd6},     // R8 groups of 4
    '{7'd8,  64'h0F, 1,0,0,1,0,0, 3'd4, 2'd0, 64'hAA, 32'd0, 32'd1, 32'd3},     // R4 inverted pred
    '{7'd8,  64'h55, 0,1,0,1,0,1, 3'd0, 2'd0, 64'h0,  32'd7, 32'd0, 32'd7},     // R5 zeroing, R3
    '{7'd8,  64'hFE, 0,1,1,1,0,0, 3'd0, 2'd0, 64'h0,  32'd7, 32'd0, 32'd7},     // R5 zeroing ff
    '{7'd5,  64'h0,  0,0,0,0,1,1, 3'd0, 2'd0, 64'h0,  32'd0, 32'd0, 32'd0},     // R13 no active, R3, R9
    '{7'd0,  ALL,    0,0,0,1,0,1, 3'd0, 2'd0, 64'h3C, 32'd0, 32'd0, 32'd0},     // R13 VL zero
    '{7'd64, ALL,    0,0,0,0,0,0, 3'd6, 2'd0, 64'h0,  32'd0, 32'd1, 32'd64},    // R6 full length
    '{7'd4,  ALL,    0,0,0,1,0,1, 3'd2, 2'd0, 64'h0,  32'd1, 32'd0, 32'd1},     // R2 reserved code
    '{7'd8,  64'hF7, 0,0,1,1,0,0, 3'd1, 2'd0, 64'h0,  32'd0, 32'd1, 32'd3},     // R4 skip under ff
    '{7'd6,  ALL,    0,0,1,1,0,0, 3'd6, 2'd0, 64'h0,  32'd0, 32'd1, 32'd5}      // R7 fail on last
  };
  localparam string VTAG [NV] = '{"R9","R10","R11","R12","R7","R7","R8","R4",
                                  "R5","R5","R13","R13","R6","R2","R4","R7"};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vlIn = '0;
  logic [63:0] predIn = '0, priorMask = '0;
  logic        srcInvert = 0, srcZeroing = 0, failFirst = 0;
  logic        dstPresent = 0, dstInvert = 0, dstZeroing = 0;
  logic [2:0]  relSel = '0;
  logic [1:0]  subVlLog2 = '0;
  logic [5:0]  elemIdx;
  logic [W-1:0] aElem, bElem;
  logic [63:0] resultMask;
  logic [6:0]  vlOut;
  logic        branchTaken, done;

  logic [W-1:0] opA [64];
  logic [W-1:0] opB [64];
  assign aElem = opA[elemIdx];
  assign bElem = opB[elemIdx];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  vec_cmp_branch #(.ELEM_W(W), .MAX_VL(64)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .vlIn(vlIn), .predIn(predIn),
    .srcInvert(srcInvert), .srcZeroing(srcZeroing), .failFirst(failFirst),
    .dstPresent(dstPresent), .dstInvert(dstInvert), .dstZeroing(dstZeroing),
    .priorMask(priorMask), .relSel(relSel), .subVlLog2(subVlLog2),
    .elemIdx(elemIdx), .aElem(aElem), .bElem(bElem), .resultMask(resultMask),
    .vlOut(vlOut), .branchTaken(branchTaken), .done(done)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lowOnes(input int n);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic relPass(input logic [2:0] r, input logic [31:0] a, input logic [31:0] b);
    case (r)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd4: return $signed(a) < $signed(b);
      3'd5: return !($signed(a) < $signed(b));
      3'd6: return a < b;
      3'd7: return !(a < b);
      default: return 1'b0;
    endcase
  endfunction

  // Reference model built from the requirements.
  task automatic model(input vec_t v, output logic [63:0] m, output logic [6:0] nv, output logic br);
    logic [63:0] ep, act, rng;
    logic stopped = 1'b0;
    int grp = 1 << v.sub;
    ep = (v.sInv ? ~v.pred : v.pred) & lowOnes(int'(v.vl));
    m  = (!v.hasDst || v.sZero) ? lowOnes(int'(v.vl)) : v.prior;
    nv = v.vl;
    if (v.vl != 0 && ep != 0) begin
      for (int i = 0; i < int'(v.vl); i++) begin
        if (!stopped) begin
          logic p, f;
          p = relPass(v.rel, v.aBase + 32'(i) * v.aStep, v.bConst);
          if (ep[i]) m[i] = p;
          else if (v.sZero) m[i] = 1'b0;
          f = ep[i] ? !p : v.sZero;
          if (f && v.ff) begin
            nv = 7'(i - (i % grp));
            stopped = 1'b1;
          end
        end
      end
    end
    rng = lowOnes(int'(nv));
    act = ep & rng;
    case ({v.hasDst && v.dInv, v.hasDst && v.dZero})
      2'b00: br = ((m & act) == act);
      2'b10: br = ((m & act) != act);
      2'b01: br = ((m & rng) != 0);
      default: br = ((m & rng) == 0);
    endcase
  endtask

  task automatic apply(input vec_t v);
    vlIn = v.vl; predIn = v.pred; srcInvert = v.sInv; srcZeroing = v.sZero;
    failFirst = v.ff; dstPresent = v.hasDst; dstInvert = v.dInv; dstZeroing = v.dZero;
    relSel = v.rel; subVlLog2 = v.sub; priorMask = v.prior;
    for (int i = 0; i < 64; i++) begin
      opA[i] = v.aBase + 32'(i) * v.aStep;
      opB[i] = v.bConst;
    end
  endtask

  // Runs one operation; optional second start while busy (must be ignored).
  task automatic runVec(input vec_t v, input string req, input bit busyPoke);
    logic [63:0] em; logic [6:0] ev; logic eb;
    int wait_n = 0;
    model(v, em, ev, eb);
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busyPoke) begin
      @(negedge clk);
      start = 1'b1; vlIn = 7'd3; predIn = 64'h1; failFirst = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    check(req, "done seen", {63'b0, done}, 64'd1);
    check(req, "resultMask", resultMask, em);
    check(req, "vlOut", {57'b0, vlOut}, {57'b0, ev});
    check(req, "branchTaken", {63'b0, branchTaken}, {63'b0, eb});
    @(negedge clk);
    check("R1", "done single cycle", {63'b0, done}, 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin opA[i] = '0; opB[i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset done", {63'b0, done}, 64'd0);
    check("R1", "reset branch", {63'b0, branchTaken}, 64'd0);
    check("R1", "reset mask", resultMask, 64'd0);
    check("R1", "reset vlOut", {57'b0, vlOut}, 64'd0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) runVec(VECS[k], VTAG[k], 1'b0);

    // R1 start ignored while busy: result must match the first configuration.
    runVec(VECS[5], "R1", 1'b1);

    // R1 outputs hold after done while inputs move.
    begin
      logic [63:0] m0; logic [6:0] v0; logic b0;
      m0 = resultMask; v0 = vlOut; b0 = branchTaken;
      apply(VECS[3]);
      repeat (4) @(negedge clk);
      check("R1", "mask holds", resultMask, m0);
      check("R1", "vlOut holds", {57'b0, vlOut}, {57'b0, v0});
      check("R1", "branch holds", {63'b0, branchTaken}, {63'b0, b0});
      check("R1", "no spurious done", {63'b0, done}, 64'd0);
    end

    // R9 without a destination, the all-pass rule applies even with invert set.
    runVec('{7'd4, ALL, 0,0,0,0,1,0, 3'd0, 2'd0, 64'h0, 32'd1, 32'd0, 32'd1}, "R9", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule